// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block produces the sampling enable for a serial port. On a single reference clock it emits a one-cycle enable pulse at sixteen times the serial bit rate. The serial transmitter uses the pulse to pace its bit shifting, and the receiver uses the same pulse to sample. The output is a clock enable in the reference clock domain, not a derived clock.

The rate is set in two stages. A prescaler passes the reference clock straight through, or divides it by four, depending on a select bit. A 16-bit divisor then divides the prescaler output. Software loads the divisor one byte at a time, low and high, and the select bit through a control byte, all on a simple write port. The tick rate is the reference rate divided by the prescale factor P and by the divisor D. Any write to a divisor byte restarts both counters, so the first period after a write always has full length.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, tick_16x is low. Reset sets the divisor to 1 and the prescale select to 0, so tick_16x is high on every cycle from the first clock edge after reset is released.
- R2: With prescale select 0 and divisor D, tick_16x goes high once every D cycles.
- R3: With prescale select 1 and divisor D, tick_16x goes high once every 4*D cycles.
- R4: A write to address 2 sets the prescale select from data bit 7. The other data bits of that write have no effect.
- R5: A write to address 0 sets the low divisor byte and a write to address 1 sets the high byte. The divisor is {high, low}, and writing one byte leaves the other unchanged.
- R6: A divisor value of 0 behaves as a divisor of 1.
- R7: When a divisor byte is written on clock edge E, tick_16x is next high exactly after edge E+P*D, and then every P*D cycles. It is never later than that.
- R8: When P*D is greater than 1, each tick_16x pulse lasts exactly one cycle.
- R9: A write to address 3 changes neither the rate nor the phase of tick_16x.
- R10: A divisor of 65535 with prescale select 0 gives a period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 2 | Register select: 0 low divisor byte, 1 high divisor byte, 2 control, 3 unused |
| wr_data | input | 8 | Write data; on a control write, bit 7 is the prescale select |
| tick_16x | output | 1 | Registered one-cycle enable at 16x the bit rate |

## Verification
The tick is registered, so its phase counts from the clock edge that takes in the final divisor byte write. The output is high after edges E+P*D, E+2*P*D and so on, and low after every other edge. After each write the bench counts edges from E and samples tick_16x on each falling edge. It compares the sample against n mod P*D, so that each expected value falls in the same cycle as the output it checks. The reset release is handled the same way, with the release edge taking the place of E. A write to the unused address is inserted one edge after the reload, and the bench carries its count through that write without resetting it.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    PRE_BYPASS  = 1'b0,
    PRE_QUARTER = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int PSEL_BIT = 7,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  divisor,
  output pre_mode_e         pre_mode,
  output logic              reload
);
  localparam int NBYTES    = DIV_W / BYTE_W;
  localparam int CTRL_ADDR = NBYTES;

  logic [DIV_W-1:0] div_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        div_q[i*BYTE_W +: BYTE_W] <= (i == 0) ? BYTE_W'(1) : '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        div_q[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pre_mode <= PRE_BYPASS;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
      pre_mode <= pre_mode_e'(wr_data[PSEL_BIT]);
  end

  assign divisor = div_q;
  assign reload  = wr_en && (wr_addr < ADDR_W'(NBYTES));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      reload,
  input  pre_mode_e mode,
  output logic      step
);
  localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(PRE_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload)
      cnt <= '0;
    else if (cnt == TERM)
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end

  assign step = (mode == PRE_BYPASS) || (cnt == TERM);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             step,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] eff;
  logic             last;

  assign eff  = (divisor == '0) ? DIV_W'(1) : divisor;
  assign last = (cnt >= eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= step && last;
      if (step)
        cnt <= last ? '0 : cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int PSEL_BIT = 7,
  parameter int PRE_DIV  = 4,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick_16x
);
  logic [DIV_W-1:0] divisor;
  pre_mode_e        pre_mode;
  logic             reload;
  logic             pre_step;

  baud_cfg_regs #(
    .DIV_W(DIV_W), .BYTE_W(BYTE_W), .PSEL_BIT(PSEL_BIT), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .divisor(divisor), .pre_mode(pre_mode), .reload(reload)
  );

  baud_prescaler #(.PRE_DIV(PRE_DIV)) pre_i (
    .clk(clk), .rst(rst), .reload(reload), .mode(pre_mode), .step(pre_step)
  );

  baud_divider #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .reload(reload), .step(pre_step),
    .divisor(divisor), .tick(tick_16x)
  );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int DIV_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int PSEL_BIT = 7,
  parameter int PRE_DIV  = 4,
  parameter int ADDR_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              tick_16x
);
  localparam int NBYTES = DIV_W / BYTE_W;
  localparam int PW     = DIV_W + $clog2(PRE_DIV) + 2;

  logic [DIV_W-1:0] s_div;
  logic             s_psel;
  logic             dirty;
  logic [PW-1:0]    gap;
  logic [PW-1:0]    pd;
  logic             div_wr;
  logic             ctrl_wr;

  assign div_wr  = wr_en && (wr_addr < ADDR_W'(NBYTES));
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(NBYTES));
  assign pd = (s_psel ? PW'(PRE_DIV) : PW'(1)) *
              ((s_div == '0) ? PW'(1) : PW'(s_div));

  always_ff @(posedge clk) begin
    if (rst) begin
      s_div  <= DIV_W'(1);
      s_psel <= 1'b0;
      dirty  <= 1'b0;
      gap    <= '0;
    end else begin
      for (int i = 0; i < NBYTES; i++)
        if (wr_en && wr_addr == ADDR_W'(i))
          s_div[i*BYTE_W +: BYTE_W] <= wr_data;
      if (ctrl_wr) begin
        s_psel <= wr_data[PSEL_BIT];
        dirty  <= 1'b1;
      end else if (div_wr) begin
        dirty <= 1'b0;
      end
      if (div_wr)          gap <= '0;
      else if (tick_16x)   gap <= PW'(1);
      else if (gap != '1)  gap <= gap + PW'(1);
    end
  end

  // R1: first cycle after reset release shows the cleared output
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tick_16x);

  // R7 (also R2, R3, R6): a tick lands exactly P*D edges after the previous event
  p_tick_period_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_16x && !dirty) |-> (gap == pd));

  // R7: the tick is never late
  p_no_late_r7: assert property (@(posedge clk) disable iff (rst)
    !dirty |-> (gap <= pd));

  // R8: single-cycle pulse when the period exceeds one
  p_single_r8: assert property (@(posedge clk) disable iff (rst)
    (tick_16x && !dirty && pd > PW'(1)) |=> !tick_16x);
endmodule

bind baud_tick_gen baud_tick_chk #(
  .DIV_W(DIV_W), .BYTE_W(BYTE_W), .PSEL_BIT(PSEL_BIT),
  .PRE_DIV(PRE_DIV), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick_16x(tick_16x)
);

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_16x;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_16x(tick_16x)
  );

  task automatic check(input bit got, input bit exp, input string req, input int n);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: cycle %0d tick_16x got %0b expected %0b", req, n, got, exp);
    end
  endtask

  // Starts at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // n counts rising edges since the reload edge
  task automatic observe(input int pd, input int first_n, input int last_n, input string req);
    for (int n = first_n; n <= last_n; n++) begin
      @(negedge clk);
      check(tick_16x, (n % pd) == 0, req, n);
    end
  endtask

  task automatic run_cfg(input logic [7:0] ctrl, input int d, input bit spare,
                         input int periods, input string req);
    int pd;
    wr(2'd2, ctrl);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
    pd = (ctrl[7] ? 4 : 1) * ((d == 0) ? 1 : d);
    if (spare) begin
      wr(2'd3, 8'hFF);              // R9: must not disturb phase
      observe(pd, 2, periods * pd, req);
    end else begin
      observe(pd, 1, periods * pd, req);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(tick_16x, 1'b0, "R1 reset", 0);
    rst = 1'b0;
    observe(1, 1, 12, "R1 default rate");

    run_cfg(8'h00, 2,   0, 4, "R2 D=2");
    run_cfg(8'h7F, 3,   0, 4, "R4 R2 D=3 other ctrl bits");
    run_cfg(8'h00, 7,   0, 3, "R2 R8 D=7");
    run_cfg(8'h00, 0,   0, 6, "R6 D=0 bypass");
    run_cfg(8'h80, 1,   0, 4, "R3 D=1");
    run_cfg(8'h95, 2,   0, 3, "R3 R4 D=2");
    run_cfg(8'h80, 5,   1, 3, "R9 R3 D=5 spare write");
    run_cfg(8'h80, 0,   0, 4, "R6 R3 D=0");
    run_cfg(8'h00, 300, 0, 3, "R5 D=0x012C");
    // R5 R7: rewrite only the low byte -> 0x0105 = 261
    wr(2'd0, 8'h05);
    observe(261, 1, 2 * 261, "R5 R7 low-byte rewrite");
    run_cfg(8'h00, 512, 1, 2, "R5 R9 high byte only");
    run_cfg(8'h80, 300, 0, 2, "R3 R5 D=300 quarter");
    run_cfg(8'h00, 65535, 0, 1, "R10 max divisor");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule